// File: doc/BRIEF.md
# Video Bus-Request Scheduler

This block decides when a raster video controller must take the memory bus away from the processor, and drives the active-low bus-available line (`ba_n`) that warns the processor in advance. It watches the horizontal pixel position of the beam. On a line that needs character and colour data, it opens one wide request window that wraps across the end of the line. For each sprite that is active on the line, it opens a shorter request window. Each window opens some cycles before the memory accesses it protects, so a processor that sees `ba_n` fall can finish its pending writes before the bus is taken.

The character window spans the horizontal blanking edge and the left part of the visible area. It covers the 40 character reads and the 40 colour reads, and it closes while the display is still showing pixels. The window for sprite 0 opens on the exact pixel where the character window closes. The later sprites follow at a fixed stride in pixels. When a sprite is fetched for the first time in a frame, its window opens half a bus cycle (four pixels) late. On a character-fetch line this leaves a short high pulse on `ba_n` between the two windows.

The block holds only the decode and one register stage. It does not perform the memory accesses and does not generate addresses. The X position, the character-line flag and the sprite flags are supplied by the beam counters and the sprite logic.

Top module: `ba_sched`

## Requirements
- R1: While reset is asserted and until the first enabled clock edge after it is released, `ba_n` is 1, `char_win` is 0 and `spr_win` is all zeros.
- R2: With `bad_line`=1, the character window is active for X from 488 up to 503 and for X from 0 up to 327, inclusive. It wraps across the end of the 504-pixel line. It is inactive for X from 328 up to 487.
- R3: With `bad_line`=0, the character window is never active.
- R4: With `spr_active[0]`=1 and `spr_first[0]`=0, the sprite 0 window is active for X from 328 up to 367 inclusive. So it opens exactly where the character window closes.
- R5: The window for sprite i opens at X = 328 + 16·i and stays open for 40 pixels. Sprite 1 therefore covers 344..383 and sprite 7 covers 440..479.
- R6: With `spr_first[i]`=1, the opening of sprite i's window moves 4 pixels later and its closing point stays the same. For sprite 0 on a character line, `ba_n` is high for X 328..331.
- R7: A sprite whose `spr_active` bit is 0 has no window, whatever its `spr_first` bit is.
- R8: `ba_n` is 0 exactly when the character window or at least one sprite window is active.
- R9: All outputs reflect the inputs sampled at the previous rising clock edge with `pix_en`=1. They hold their value across edges with `pix_en`=0.
- R10: An X value of 504 or more opens no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_en | input | 1 | Clock enable; inputs are sampled on edges where it is 1 |
| x_pos | input | 9 | Current horizontal beam position in pixels (0..503) |
| bad_line | input | 1 | Current line needs a character/colour fetch |
| spr_active | input | 8 | One bit per sprite: sprite data is fetched on this line |
| spr_first | input | 8 | One bit per sprite: this is the sprite's first fetched line |
| ba_n | output | 1 | Active-low bus-available request to the processor |
| char_win | output | 1 | Character/colour fetch window is open |
| spr_win | output | 8 | One bit per sprite: its fetch window is open |

## Verification
Every output is due exactly one enabled clock edge after the X position and flags that select it. The bench drives inputs on the falling edge and pulses one enabled rising edge. It then reads all three outputs at the following falling edge, which places the sample half a period after the only register on the path. Boundary pixels are checked on both sides of each window edge: 327/328, 367/368, 487/488, 331/332, and the line wrap at 503/0. The check for held state drops `pix_en` and changes inputs before the next falling-edge sample.

// File: rtl/ba_sched_pkg.sv
package ba_sched_pkg;

  // True when pixel x lies inside a window that starts at 'start', lasts
  // 'len' pixels (wrapping at 'line'), and whose first 'defer' pixels are
  // suppressed. Positions at or past the line length never match.
  function automatic logic in_window(input int x, input int start,
                                     input int len, input int defer,
                                     input int line);
    int off;
    if (x >= line) return 1'b0;
    off = (x >= start) ? (x - start) : (x + line - start);
    return (off >= defer) && (off < len);
  endfunction

endpackage

// File: rtl/ba_char_decode.sv
module ba_char_decode #(
  parameter int XW       = 9,
  parameter int LINE_PIX = 504,
  parameter int CHAR_ON  = 488,
  parameter int CHAR_OFF = 328
) (
  input  logic [XW-1:0] x_pos,
  input  logic          bad_line,
  output logic          chr_nx
);
  import ba_sched_pkg::*;

  localparam int CHAR_LEN = (CHAR_OFF >= CHAR_ON) ? (CHAR_OFF - CHAR_ON)
                                                  : (LINE_PIX - CHAR_ON + CHAR_OFF);

  always_comb begin
    chr_nx = bad_line && in_window(int'(x_pos), CHAR_ON, CHAR_LEN, 0, LINE_PIX);
  end

endmodule

// File: rtl/ba_sprite_decode.sv
module ba_sprite_decode #(
  parameter int XW       = 9,
  parameter int LINE_PIX = 504,
  parameter int START    = 328,
  parameter int LEN      = 40,
  parameter int DEFER    = 4
) (
  input  logic [XW-1:0] x_pos,
  input  logic          active,
  input  logic          first,
  output logic          spr_nx
);
  import ba_sched_pkg::*;

  logic hit_full;
  logic hit_late;

  always_comb begin
    hit_full = in_window(int'(x_pos), START, LEN, 0,     LINE_PIX);
    hit_late = in_window(int'(x_pos), START, LEN, DEFER, LINE_PIX);
    spr_nx   = active && (first ? hit_late : hit_full);
  end

endmodule

// File: rtl/ba_request_reg.sv
module ba_request_reg #(
  parameter int SPR_NUM = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               chr_nx,
  input  logic [SPR_NUM-1:0] spr_nx,
  output logic               ba_n,
  output logic               char_win,
  output logic [SPR_NUM-1:0] spr_win
);

  logic               ba_n_d;
  logic               char_d;
  logic [SPR_NUM-1:0] spr_d;

  always_comb begin
    ba_n_d = ba_n;
    char_d = char_win;
    spr_d  = spr_win;
    if (en) begin
      char_d = chr_nx;
      spr_d  = spr_nx;
      ba_n_d = !(chr_nx || (|spr_nx));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ba_n     <= 1'b1;
      char_win <= 1'b0;
      spr_win  <= '0;
    end else begin
      ba_n     <= ba_n_d;
      char_win <= char_d;
      spr_win  <= spr_d;
    end
  end

  // R9: nothing moves on an edge without the enable
  p_hold_without_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable({ba_n, char_win, spr_win}));

  // R8: bus request asserted whenever any window was decoded open
  p_request_follows_windows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (chr_nx || (|spr_nx))) |=> !ba_n);

endmodule

// File: rtl/ba_sched.sv
module ba_sched #(
  parameter int XW         = 9,
  parameter int LINE_PIX   = 504,
  parameter int CHAR_ON    = 488,
  parameter int CHAR_OFF   = 328,
  parameter int SPR_NUM    = 8,
  parameter int SPR_LEN    = 40,
  parameter int SPR_STRIDE = 16,
  parameter int SPR_DEFER  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_en,
  input  logic [XW-1:0]      x_pos,
  input  logic               bad_line,
  input  logic [SPR_NUM-1:0] spr_active,
  input  logic [SPR_NUM-1:0] spr_first,
  output logic               ba_n,
  output logic               char_win,
  output logic [SPR_NUM-1:0] spr_win
);

  // Sprite 0 opens where the character window closes.
  localparam int SPR0_ON = CHAR_OFF;

  logic               rst_meta_n;
  logic               rst_sync_n;
  logic               chr_nx;
  logic [SPR_NUM-1:0] spr_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  ba_char_decode #(
    .XW(XW), .LINE_PIX(LINE_PIX), .CHAR_ON(CHAR_ON), .CHAR_OFF(CHAR_OFF)
  ) u_char (
    .x_pos(x_pos), .bad_line(bad_line), .chr_nx(chr_nx)
  );

  for (genvar i = 0; i < SPR_NUM; i++) begin : g_spr
    localparam int START = (SPR0_ON + i * SPR_STRIDE) % LINE_PIX;

    ba_sprite_decode #(
      .XW(XW), .LINE_PIX(LINE_PIX), .START(START),
      .LEN(SPR_LEN), .DEFER(SPR_DEFER)
    ) u_dec (
      .x_pos(x_pos), .active(spr_active[i]), .first(spr_first[i]),
      .spr_nx(spr_nx[i])
    );

    // R7: an idle sprite never opens its window
    p_idle_sprite_closed_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (pix_en && !spr_active[i]) |=> !spr_win[i]);

    // R6: the first pixel of a deferred window stays closed
    p_first_line_deferred_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (pix_en && spr_first[i] && (int'(x_pos) == START)) |=> !spr_win[i]);
  end

  ba_request_reg #(.SPR_NUM(SPR_NUM)) u_reg (
    .clk(clk), .rst_n(rst_sync_n), .en(pix_en),
    .chr_nx(chr_nx), .spr_nx(spr_nx),
    .ba_n(ba_n), .char_win(char_win), .spr_win(spr_win)
  );

  // R3: no character request on an ordinary line
  p_no_char_plain_line_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pix_en && !bad_line) |=> !char_win);

  // R10: positions past the line end release the bus
  p_off_line_released_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pix_en && (int'(x_pos) >= LINE_PIX)) |=> ba_n);

  // R8: a low request always has a window behind it
  p_low_needs_window_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ba_n |-> (char_win || (|spr_win)));

endmodule

// File: tb/sim_ba_sched.sv
module sim_ba_sched;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 24;

  typedef struct packed {
    logic [8:0] x;
    logic       bad;
    logic [7:0] act;
    logic [7:0] first;
    logic       ba;
    logic       chr;
    logic [7:0] spr;
  } vec_t;

  // x, bad_line, active, first, expected ba_n, char_win, spr_win
  localparam vec_t VECS [NVEC] = '{
    {9'd0,   1'b1, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00},  // R2 wrap side
    {9'd327, 1'b1, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00},  // R2 last pixel
    {9'd328, 1'b1, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00},  // R2 closed
    {9'd487, 1'b1, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00},  // R2 before open
    {9'd488, 1'b1, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00},  // R2 open
    {9'd503, 1'b1, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00},  // R2 line end
    {9'd100, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00},  // R3
    {9'd490, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00},  // R3
    {9'd328, 1'b0, 8'h01, 8'h00, 1'b0, 1'b0, 8'h01},  // R4 open
    {9'd367, 1'b0, 8'h01, 8'h00, 1'b0, 1'b0, 8'h01},  // R4 last
    {9'd368, 1'b0, 8'h01, 8'h00, 1'b1, 1'b0, 8'h00},  // R4 closed
    {9'd327, 1'b1, 8'h01, 8'h00, 1'b0, 1'b1, 8'h00},  // R4 handover
    {9'd328, 1'b1, 8'h01, 8'h01, 1'b1, 1'b0, 8'h00},  // R6 glitch
    {9'd331, 1'b1, 8'h01, 8'h01, 1'b1, 1'b0, 8'h00},  // R6 glitch end
    {9'd332, 1'b1, 8'h01, 8'h01, 1'b0, 1'b0, 8'h01},  // R6 deferred open
    {9'd367, 1'b0, 8'h01, 8'h01, 1'b0, 1'b0, 8'h01},  // R6 same close
    {9'd343, 1'b0, 8'h02, 8'h00, 1'b1, 1'b0, 8'h00},  // R5 sprite1 before
    {9'd344, 1'b0, 8'h02, 8'h00, 1'b0, 1'b0, 8'h02},  // R5 sprite1 open
    {9'd479, 1'b0, 8'h80, 8'h00, 1'b0, 1'b0, 8'h80},  // R5 sprite7 last
    {9'd480, 1'b0, 8'h80, 8'h00, 1'b1, 1'b0, 8'h00},  // R5 sprite7 closed
    {9'd443, 1'b0, 8'h80, 8'h80, 1'b1, 1'b0, 8'h00},  // R6 sprite7 deferred
    {9'd350, 1'b0, 8'h03, 8'h00, 1'b0, 1'b0, 8'h03},  // R8 overlap
    {9'd328, 1'b0, 8'h00, 8'hFF, 1'b1, 1'b0, 8'h00},  // R7
    {9'd505, 1'b1, 8'hFF, 8'h00, 1'b1, 1'b0, 8'h00}   // R10
  };

  logic       clk;
  logic       rst_n;
  logic       pix_en;
  logic [8:0] x_pos;
  logic       bad_line;
  logic [7:0] spr_active;
  logic [7:0] spr_first;
  logic       ba_n;
  logic       char_win;
  logic [7:0] spr_win;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  ba_sched u0 (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .x_pos(x_pos),
    .bad_line(bad_line), .spr_active(spr_active), .spr_first(spr_first),
    .ba_n(ba_n), .char_win(char_win), .spr_win(spr_win)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic apply(input logic [8:0] x, input logic bad,
                       input logic [7:0] act, input logic [7:0] first);
    @(negedge clk);
    x_pos = x; bad_line = bad; spr_active = act; spr_first = first; pix_en = 1'b1;
    @(negedge clk);
    pix_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pix_en = 1'b0; x_pos = '0; bad_line = 1'b1;
    spr_active = 8'hFF; spr_first = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state, even with inputs that would open windows
    chk("R1 ba_n", {31'd0, ba_n}, 32'd1);
    chk("R1 char_win", {31'd0, char_win}, 32'd0);
    chk("R1 spr_win", {24'd0, spr_win}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ba_n after release", {31'd0, ba_n}, 32'd1);

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].x, VECS[i].bad, VECS[i].act, VECS[i].first);
      chk($sformatf("vec%0d ba_n R8", i), {31'd0, ba_n}, {31'd0, VECS[i].ba});
      chk($sformatf("vec%0d char_win R2", i), {31'd0, char_win}, {31'd0, VECS[i].chr});
      chk($sformatf("vec%0d spr_win R5", i), {24'd0, spr_win}, {24'd0, VECS[i].spr});
    end

    // R9: outputs hold while the enable is low
    apply(9'd400, 1'b0, 8'h00, 8'h00);
    chk("R9 setup", {31'd0, ba_n}, 32'd1);
    @(negedge clk);
    x_pos = 9'd0; bad_line = 1'b1; spr_active = 8'h00; spr_first = 8'h00;
    repeat (3) @(negedge clk);
    chk("R9 hold ba_n", {31'd0, ba_n}, 32'd1);
    chk("R9 hold char_win", {31'd0, char_win}, 32'd0);
    pix_en = 1'b1;
    @(negedge clk);
    pix_en = 1'b0;
    chk("R9 update ba_n", {31'd0, ba_n}, 32'd0);

    // R2 R4 R8: full-line sweep on a character line with sprite 0 active
    for (int x = 0; x < 504; x++) begin
      logic ec, es;
      apply(x[8:0], 1'b1, 8'h01, 8'h00);
      ec = (x >= 488) || (x < 328);
      es = (x >= 328) && (x < 368);
      chk($sformatf("sweep x=%0d R2", x), {31'd0, char_win}, {31'd0, ec});
      chk($sformatf("sweep x=%0d R4", x), {31'd0, spr_win[0]}, {31'd0, es});
      chk($sformatf("sweep x=%0d R8", x), {31'd0, ba_n}, {31'd0, !(ec || es)});
    end

    // R1: reset mid-window clears everything
    apply(9'd10, 1'b1, 8'h00, 8'h00);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 async clear", {30'd0, ba_n, char_win}, 32'd2);
    rst_n = 1'b1;

    finish_run();
  end

endmodule